// File: doc/BRIEF.md
# Serial Flash Read Master

This block is an SPI master that fetches firmware bytes from an external serial flash. It runs from the system clock and makes the serial clock from a programmable divider, so that each SCLK level lasts `baud_div_i + 1` system clocks. The serial interface uses mode 0: SCLK idles low, the flash samples on the rising edge, and both sides change data on the falling edge. Bits go out MSB first.

A command gives an 8-bit opcode, a 24-bit address and a byte count. With chip select held low, the block shifts out the opcode and then the address. It then clocks in the requested number of bytes and presents each one on a valid/ready output stream. If the stream is back-pressured, the block does not drop data. It parks SCLK low before the first edge of the next byte and waits until the pending byte has been taken.

Chip select leads the first SCLK edge by one half period and trails the last SCLK edge by one half period. After a transfer, chip select stays high for at least `32*gap_dly_i + 6` system clocks plus one half SCLK period. Until that time has passed, the command port is not ready.

Top module: `spi_flash_rd`

## Requirements
- R1: SCLK is low whenever chip select is high. While chip select is low, every high and every low SCLK phase lasts exactly `baud_div_i + 1` system clocks, unless the output stream stalls (R8).
- R2: The first rising SCLK edge comes exactly `baud_div_i + 1` system clocks after chip select falls.
- R3: Chip select rises exactly `baud_div_i + 1` system clocks after the last falling SCLK edge.
- R4: After chip select rises, it stays high for exactly `32*gap_dly_i + 6 + baud_div_i + 1` system clocks when the next command is already waiting. During that time `cmd_ready_o` is low.
- R5: The first 32 bits on MOSI are the opcode followed by the 24-bit address, MSB first. MOSI changes only on falling SCLK edges, so it is stable while SCLK is high. MOSI is low during the data phase and while idle.
- R6: MISO is sampled on rising SCLK edges, MSB first. Each group of 8 bits after the header is one byte on `rd_data_o`, and bytes leave in the order they were received. Exactly `cmd_len_i` bytes are delivered.
- R7: A transfer has exactly `32 + 8*cmd_len_i` rising SCLK edges. A byte count of zero sends only the header.
- R8: While `rd_valid_o` is high and `rd_ready_i` is low, `rd_data_o` holds steady. SCLK stays low before the first edge of the next byte until the pending byte is accepted, and no byte is lost.
- R9: `cmd_ready_o` is high only when the block is idle and the gap time of R4 has expired. A command offered while `cmd_ready_o` is low does not disturb the transfer in progress.
- R10: After reset, chip select is high, SCLK and MOSI are low, `rd_valid_o` is low and `cmd_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_div_i | input | DIV_W | Divider value; each SCLK level lasts this value plus one clock. Latched when a command is accepted |
| gap_dly_i | input | DT_W | Delay value for the minimum chip-select-high time |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command accepted when both valid and ready are high |
| cmd_opcode_i | input | 8 | Read opcode |
| cmd_addr_i | input | 24 | Start address |
| cmd_len_i | input | LEN_W | Number of bytes to read |
| rd_data_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | Received byte is valid |
| rd_ready_i | input | 1 | Consumer takes the byte |
| spi_sclk_o | output | 1 | Serial clock |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
The assertions check several rules on every cycle:
- SCLK is low whenever chip select is high.
- SCLK cannot change while the half-period counter is still running.
- MOSI holds steady while SCLK is high.
- A held byte on the output stream stays put.
- SCLK stays parked while a byte is pending at a byte boundary.
- The gap counter steps down one count at a time.
- The command port stays closed while a transfer or gap is running.

Only the bench scenarios can show the exact cycle counts of setup, hold and gap against the arithmetic formulas. The same goes for the opcode and address seen by a flash model, the byte contents and order over a sweep of divider, length and delay values, and recovery from a long back-pressure stall.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int OPC_W    = 8;
  localparam int ADR_W    = 24;
  localparam int HDR_BYTES = (OPC_W + ADR_W) / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD
  } spi_st_e;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             done_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= half_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - DIV_W'(1);
  end

  assign done_o = (cnt_q == '0);

  // R1: a running phase count never jumps upward without a reload
  a_r1_half_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - DIV_W'(1)));
endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
  parameter int DT_W  = 4,
  parameter int DIV_W = 8,
  parameter int MULT  = 32,
  parameter int OFFS  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DT_W-1:0]  dt_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             busy_o
);
  localparam int MUL_W = DT_W + $clog2(MULT) + 1;
  localparam int GAP_W = ((MUL_W > DIV_W) ? MUL_W : DIV_W) + 2;

  logic [GAP_W-1:0] scaled, load_val, cnt_q;

  generate
    if ((MULT & (MULT - 1)) == 0) begin : g_pow2
      assign scaled = GAP_W'(dt_i) << $clog2(MULT);
    end else begin : g_mul
      assign scaled = GAP_W'(dt_i) * GAP_W'(MULT);
    end
  endgenerate

  // total high time = MULT*dt + OFFS + (div+1); counter ends one early
  assign load_val = scaled + GAP_W'(OFFS) + GAP_W'(div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - GAP_W'(1);
  end

  assign busy_o = (cnt_q != '0);

  a_r4_gap_counts_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - GAP_W'(1)));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int HDR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic             shift_i,
  input  logic             sample_i,
  input  logic             miso_i,
  output logic             mosi_o,
  output logic [7:0]       rx_next_o
);
  logic [HDR_W-1:0] tx_q;
  logic [6:0]       rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tx_q <= '0;
    else if (load_i)   tx_q <= hdr_i;
    else if (shift_i)  tx_q <= {tx_q[HDR_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rx_q <= '0;
    else if (sample_i)  rx_q <= rx_next_o[6:0];
  end

  assign mosi_o    = tx_q[HDR_W-1];
  assign rx_next_o = {rx_q, miso_i};
endmodule

// File: rtl/spi_flash_rd.sv
module spi_flash_rd
  import spi_rd_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DT_W     = 4,
  parameter int LEN_W    = 16,
  parameter int GAP_MULT = 32,
  parameter int GAP_OFFS = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic [DT_W-1:0]  gap_dly_i,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [7:0]       cmd_opcode_i,
  input  logic [23:0]      cmd_addr_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic             spi_sclk_o,
  output logic             spi_cs_no,
  output logic             spi_mosi_o,
  input  logic             spi_miso_i
);
  localparam int HDR_W = OPC_W + ADR_W;
  localparam int HB_W  = $clog2(HDR_BYTES + 1);

  spi_st_e          state_q;
  logic             sclk_q, cs_n_q, last_q, valid_q;
  logic [2:0]       bit_idx_q;
  logic [HB_W-1:0]  hdr_left_q;
  logic [LEN_W-1:0] data_left_q;
  logic [DIV_W-1:0] div_q, half_val;
  logic [7:0]       data_q, rx_next;

  logic accept, rise_ev, fall_ev, end_ev, half_load, half_done;
  logic gap_busy, byte_end, in_data, stall;

  assign in_data  = (hdr_left_q == '0);
  assign byte_end = (bit_idx_q == 3'd7);
  // hold SCLK low at a data byte boundary while the last byte is unread
  assign stall    = in_data && (bit_idx_q == 3'd0) && valid_q;

  assign accept    = (state_q == ST_IDLE) && !gap_busy && cmd_valid_i;
  assign rise_ev   = (state_q == ST_SETUP || state_q == ST_LOW) && half_done && !stall;
  assign fall_ev   = (state_q == ST_HIGH) && half_done;
  assign end_ev    = (state_q == ST_HOLD) && half_done;
  assign half_load = accept || rise_ev || fall_ev;
  assign half_val  = accept ? baud_div_i : div_q;

  spi_half_timer #(.DIV_W(DIV_W)) u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (half_load),
    .half_i (half_val),
    .done_o (half_done)
  );

  spi_gap_timer #(.DT_W(DT_W), .DIV_W(DIV_W), .MULT(GAP_MULT), .OFFS(GAP_OFFS)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (end_ev),
    .dt_i   (gap_dly_i),
    .div_i  (div_q),
    .busy_o (gap_busy)
  );

  spi_shifter #(.HDR_W(HDR_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .hdr_i     ({cmd_opcode_i, cmd_addr_i}),
    .shift_i   (fall_ev),
    .sample_i  (rise_ev),
    .miso_i    (spi_miso_i),
    .mosi_o    (spi_mosi_o),
    .rx_next_o (rx_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sclk_q      <= 1'b0;
      cs_n_q      <= 1'b1;
      last_q      <= 1'b0;
      bit_idx_q   <= '0;
      hdr_left_q  <= '0;
      data_left_q <= '0;
      div_q       <= '0;
    end else begin
      if (accept) begin
        state_q     <= ST_SETUP;
        cs_n_q      <= 1'b0;
        div_q       <= baud_div_i;
        bit_idx_q   <= '0;
        hdr_left_q  <= HB_W'(HDR_BYTES);
        data_left_q <= cmd_len_i;
        last_q      <= 1'b0;
      end
      if (rise_ev) begin
        state_q   <= ST_HIGH;
        sclk_q    <= 1'b1;
        bit_idx_q <= bit_idx_q + 3'd1;
        last_q    <= byte_end &&
                     ((hdr_left_q == HB_W'(1) && data_left_q == '0) ||
                      (in_data && data_left_q == LEN_W'(1)));
        if (byte_end) begin
          if (!in_data) hdr_left_q  <= hdr_left_q - HB_W'(1);
          else          data_left_q <= data_left_q - LEN_W'(1);
        end
      end
      if (fall_ev) begin
        sclk_q  <= 1'b0;
        state_q <= last_q ? ST_HOLD : ST_LOW;
      end
      if (end_ev) begin
        cs_n_q  <= 1'b1;
        state_q <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (rise_ev && byte_end && in_data) begin
      valid_q <= 1'b1;
      data_q  <= rx_next;
    end else if (rd_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE) && !gap_busy;
  assign spi_sclk_o  = sclk_q;
  assign spi_cs_no   = cs_n_q;
  assign rd_valid_o  = valid_q;
  assign rd_data_o   = data_q;

  a_r1_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sclk_o);

  a_r1_phase_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!half_done && state_q inside {ST_SETUP, ST_LOW, ST_HIGH}) |=> $stable(spi_sclk_o));

  a_r2_cs_falls_sclk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_cs_no) |-> !spi_sclk_o);

  a_r5_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sclk_o |=> (!spi_sclk_o || $stable(spi_mosi_o)));

  a_r8_hold_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

  a_r8_park_sclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i && state_q == ST_LOW && in_data && bit_idx_q == 3'd0)
      |=> !spi_sclk_o);

  a_r9_ready_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (spi_cs_no && !spi_sclk_o));

  a_r4_no_ready_at_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_cs_no) |-> !cmd_ready_o);
endmodule

// File: tb/spi_flash_rd_bench.sv
module spi_flash_rd_bench;
  localparam int DIV_W = 4;
  localparam int DT_W  = 3;
  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [DIV_W-1:0] baud_div = '0;
  logic [DT_W-1:0]  gap_dly = '0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [7:0]       cmd_op = '0;
  logic [23:0]      cmd_addr = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [7:0]       rd_data;
  logic             rd_valid;
  logic             rd_ready = 1'b1;
  logic             sclk, cs_n, mosi;
  logic             miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_flash_rd #(.DIV_W(DIV_W), .DT_W(DT_W), .LEN_W(LEN_W)) u_spi_flash_rd (
    .clk_i(clk), .rst_ni(rst_ni), .baud_div_i(baud_div), .gap_dly_i(gap_dly),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_opcode_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_len_i(cmd_len), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .spi_sclk_o(sclk),
    .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fmem(logic [23:0] a);
    return 8'(a[7:0] * 8'd29) ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  // flash model
  int          s_bits = 0, s_ones = 0;
  logic [31:0] s_hdr = '0;
  always @(negedge cs_n) begin
    s_bits = 0; s_hdr = '0; s_ones = 0;
  end
  always @(posedge sclk) if (!cs_n) begin
    if (s_bits < 32) s_hdr = {s_hdr[30:0], mosi};
    else if (mosi) s_ones++;
    s_bits++;
  end
  always @(negedge sclk) if (!cs_n && s_bits >= 32) begin : drv
    logic [7:0] b;
    int k;
    k = s_bits - 32;
    b = fmem(s_hdr[23:0] + 24'(k / 8));
    miso = b[7 - (k % 8)];
  end

  // timing monitor
  logic prev_sclk = 1'b0, prev_cs = 1'b1, first_low = 1'b0;
  int   ph_len = 0, setup_len = 0, hold_len = 0, n_rise = 0;
  int   bad_hi = 0, bad_lo = 0, gap_len = 0, gap_seen = 0, done_cnt = 0, exp_h = 1;
  always @(negedge clk) begin
    if (!cs_n) begin
      if (prev_cs) begin
        gap_seen = gap_len; ph_len = 1; first_low = 1'b1;
        n_rise = 0; bad_hi = 0; bad_lo = 0;
      end else if (sclk != prev_sclk) begin
        if (prev_sclk) begin
          if (ph_len != exp_h) bad_hi++;
        end else begin
          if (first_low) setup_len = ph_len;
          else if (ph_len != exp_h) bad_lo++;
          first_low = 1'b0;
          n_rise++;
        end
        ph_len = 1;
      end else ph_len++;
    end else begin
      if (!prev_cs) begin hold_len = ph_len; done_cnt++; gap_len = 1; end
      else gap_len++;
    end
    prev_sclk = sclk; prev_cs = cs_n;
  end

  // stream consumer
  int         rdy_mode = 0, rx_n = 0, r8_err = 0;
  logic [7:0] rx_buf [16];
  logic [7:0] lfsr = 8'h01, held = '0;
  logic       hold_v = 1'b0;
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (hold_v && (!rd_valid || rd_data != held)) r8_err++;
    rd_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
    if (rd_valid && rd_ready) begin
      if (rx_n < 16) rx_buf[rx_n] = rd_data;
      rx_n++;
    end
    hold_v = rd_valid && !rd_ready;
    held   = rd_data;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic issue(logic [7:0] op, logic [23:0] ad, int len);
    cmd_op = op; cmd_addr = ad; cmd_len = LEN_W'(len); cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(int d0, int len);
    while (!(done_cnt != d0 && rx_n >= len)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_bytes(string req, logic [23:0] ad, int len);
    check(req, "byte count", rx_n, len);
    for (int i = 0; i < len; i++)
      check(req, "byte value", int'(rx_buf[i]), int'(fmem(ad + 24'(i))));
  endtask

  task automatic run_txn(logic [7:0] op, logic [23:0] ad, int len, int div, int dt,
                         int mode, bit chk_low);
    int d0;
    baud_div = DIV_W'(div); gap_dly = DT_W'(dt); exp_h = div + 1;
    rdy_mode = mode; rx_n = 0; r8_err = 0;
    d0 = done_cnt;
    issue(op, ad, len);
    wait_done(d0, len);
    check("R2", "setup cycles", setup_len, div + 1);
    check("R3", "hold cycles", hold_len, div + 1);
    check("R1", "bad high phases", bad_hi, 0);
    if (chk_low) check("R1", "bad low phases", bad_lo, 0);
    check("R5", "opcode", int'(s_hdr[31:24]), int'(op));
    check("R5", "address", int'(s_hdr[23:0]), int'(ad));
    check("R5", "mosi ones in data", s_ones, 0);
    check("R7", "rising edges", n_rise, 32 + 8 * len);
    check_bytes("R6", ad, len);
    if (mode == 1) check("R8", "held byte changed", r8_err, 0);
  endtask

  task automatic gap_test(int div, int dt);
    int d0;
    baud_div = DIV_W'(div); gap_dly = DT_W'(dt); exp_h = div + 1;
    rdy_mode = 0; rx_n = 0;
    d0 = done_cnt;
    issue(8'h0B, 24'h00_1230 + 24'(dt), 1);
    // R9: second command waits, valid held across the first transfer
    issue(8'h03, 24'h04_5600 + 24'(div), 0);
    @(negedge clk);
    check("R4", "cs high gap", gap_seen, 32 * dt + 6 + div + 1);
    check_bytes("R9", 24'h00_1230 + 24'(dt), 1);
    wait_done(d0 + 1, 1);
    check("R9", "second opcode", int'(s_hdr[31:24]), 8'h03);
    check("R9", "second address", int'(s_hdr[23:0]), int'(24'h04_5600 + 24'(div)));
    check("R7", "second rising edges", n_rise, 32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "cs_n in reset", int'(cs_n), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10", "cs_n", int'(cs_n), 1);
    check("R10", "sclk", int'(sclk), 0);
    check("R10", "mosi", int'(mosi), 0);
    check("R10", "rd_valid", int'(rd_valid), 0);
    check("R10", "cmd_ready", int'(cmd_ready), 1);

    for (int div = 0; div < 4; div++)
      for (int len = 0; len < 4; len++)
        for (int dt = 0; dt < 2; dt++)
          run_txn(8'h03 ^ 8'(len), 24'hA5_0000 + 24'(div * 64 + len * 16 + dt),
                  len, div, dt, 0, 1'b1);

    for (int div = 0; div < 3; div++)
      for (int dt = 0; dt < 4; dt++)
        gap_test(div, dt);

    for (int k = 0; k < 4; k++)
      run_txn(8'h0B, 24'h12_3400 + 24'(k * 7), 5 + k, k % 3, 1, 1, 1'b0);

    // R8: long stall with the consumer not ready
    begin
      int d0;
      baud_div = DIV_W'(1); gap_dly = '0; exp_h = 2;
      rdy_mode = 2; rx_n = 0; r8_err = 0;
      d0 = done_cnt;
      issue(8'h03, 24'h00_7FFE, 3);
      while (!rd_valid) @(negedge clk);
      repeat (100) @(negedge clk);
      check("R8", "rising edges while parked", n_rise, 40);
      check("R8", "valid while parked", int'(rd_valid), 1);
      check("R8", "parked byte", int'(rd_data), int'(fmem(24'h00_7FFE)));
      check("R8", "sclk parked low", int'(sclk), 0);
      rdy_mode = 0;
      wait_done(d0, 3);
      check_bytes("R8", 24'h00_7FFE, 3);
      check("R8", "held byte changed", r8_err, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule